// File: doc/BRIEF.md
# Serial Configuration Register Port

This block is a slave port that lets a host read and write a small bank of configuration registers over three wires: an active-low select line, a serial clock and a data line. The data line is split at the block edge into an input, an output and an output enable, so a pad or a board-level buffer can form the bidirectional wire. The serial clock, select line and input data are resynchronized into a fast system clock, and all frame handling runs in that domain.

There are eight 9-bit registers. Each frame carries a direction flag, a 3-bit address and a 9-bit payload. The block holds the registers with their fixed reset values. It clears unused bit positions on write and decodes the fields onto dedicated outputs:

- operating-mode flags;
- channel order and channel enables;
- three 6-bit gain codes;
- three offsets, converted from sign-magnitude to two's complement.

Top module: `serial_cfg_port`

## Requirements
- R1: A frame is 13 bits sent most significant bit first: a direction flag (1 = read, 0 = write), address bits A2..A0, then payload bits D8..D0. The block captures a bit on each rising edge of the serial clock while the select line is low.
- R2: A write frame updates the addressed register once all 13 bits have arrived, and the new value appears on the decoded outputs. Bits clocked in after the 13th have no effect.
- R3: In a read frame, the block drives D8..D0 of the addressed register one bit per falling edge of the serial clock, starting with the falling edge after the fourth bit. The output enable is high from that edge until the select line rises. A read changes no register.
- R4: After reset the registers hold these values: address 0 = 0x0F8, address 1 = 0x0C0, addresses 2 to 7 = 0.
- R5: Unused bit positions are cleared on write and read back as 0. Address 0 keeps bits 7..2 and bit 0. Address 1 keeps bits 7..4. Addresses 2 to 4 keep bits 5..0. Addresses 5 to 7 keep all nine bits.
- R6: Register 0 decodes to the outputs as follows: bit 7 = input range, bit 6 = internal reference enable, bit 5 = three-channel mode, bit 4 = correlated double sampling (1) versus plain sample-and-hold (0), bit 3 = clamp level, bit 2 = power-down, bit 0 = single-byte output.
- R7: Register 1 decodes to the outputs as follows: bit 7 = channel order (1 = red-green-blue, 0 = blue-green-red). Bits 6, 5 and 4 are the red, green and blue enables, presented on `ch_en_o[2]`, `ch_en_o[1]` and `ch_en_o[0]`.
- R8: Registers 2, 3 and 4 hold the red, green and blue gain codes in bits 5..0 as straight binary. They appear on `gain_o[0]`, `gain_o[1]` and `gain_o[2]`.
- R9: Registers 5, 6 and 7 hold the red, green and blue offsets in sign-magnitude form, with bit 8 as the sign. Each appears on `ofs_o[0..2]` as a 9-bit two's-complement value: code 0x001 gives +1, 0x1FF gives -255, and 0x100 gives 0.
- R10: A frame whose select line rises before 13 bits have arrived changes no register.
- R11: While the power-down bit is set, every register keeps its contents and writes are still accepted.
- R12: The output enable stays low during write frames and goes low once the select line is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock from the host |
| sel_n_i | input | 1 | Frame select, active low |
| sdi_i | input | 1 | Serial data from the host |
| sdo_o | output | 1 | Serial read data toward the host |
| sdo_oe_o | output | 1 | Drive enable for the serial data line |
| range_hi_o | output | 1 | Input range select |
| int_ref_o | output | 1 | Internal reference enable |
| three_ch_o | output | 1 | Three-channel mode |
| cds_o | output | 1 | Correlated double sampling select |
| clamp_hi_o | output | 1 | Clamp level select |
| pwrdn_o | output | 1 | Power-down request |
| single_byte_o | output | 1 | Single-byte output mode |
| order_rgb_o | output | 1 | Channel order, 1 = red first |
| ch_en_o | output | 3 | Channel enables {red, green, blue} |
| gain_o | output | 3x6 | Gain codes, index 0 red, 1 green, 2 blue |
| ofs_o | output | 3x9 | Signed offsets, index 0 red, 1 green, 2 blue |

## Verification
Two situations are the hardest to reach from the pins: the line turnaround inside a read frame, and a frame that is cut short. The turnaround requires the host to sample at the right point after each falling edge, past the synchronizer delay. A cut-short frame must leave every register exactly as it was.

The frame task takes a bit count. It can therefore stop after 6 or after 12 bits and then release the select line, and a later read frame brings the untouched register value back out. The same task records the output enable on every bit, so a drive during a write frame or a late drive after release is seen at the pins.

// File: rtl/scp_pkg.sv
package scp_pkg;
   localparam int REG_W      = 9;
   localparam int REG_ADDR_W = 3;
   localparam int NUM_CH     = 3;

   localparam int ADDR_CFG    = 0;
   localparam int ADDR_MUX    = 1;
   localparam int ADDR_GAIN_R = 2;
   localparam int ADDR_OFS_R  = 5;

   // bit positions inside the mode register
   localparam int CFG_RANGE  = 7;
   localparam int CFG_REF    = 6;
   localparam int CFG_3CH    = 5;
   localparam int CFG_CDS    = 4;
   localparam int CFG_CLAMP  = 3;
   localparam int CFG_PWRDN  = 2;
   localparam int CFG_1BYTE  = 0;
   localparam int MUX_ORDER  = 7;
   localparam int MUX_EN_LO  = 4;

   function automatic logic [REG_W-1:0] keep_mask(input int a);
      case (a)
         ADDR_CFG:   return 9'h0FD;
         ADDR_MUX:   return 9'h0F0;
         2, 3, 4:    return 9'h03F;
         default:    return 9'h1FF;
      endcase
   endfunction

   function automatic logic [REG_W-1:0] reset_val(input int a);
      case (a)
         ADDR_CFG: return 9'h0F8;
         ADDR_MUX: return 9'h0C0;
         default:  return 9'h000;
      endcase
   endfunction
endpackage

// File: rtl/scp_sync.sv
module scp_sync #(
   parameter int           STAGES  = 2,
   parameter int           W       = 1,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [STAGES-1:0][W-1:0] chain;

   if (STAGES < 2) begin : g_bad_stages
      $error("scp_sync needs at least two stages");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[0] <= RST_VAL;
      else        chain[0] <= d;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[s] <= RST_VAL;
         else        chain[s] <= chain[s-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/scp_frame.sv
module scp_frame #(
   parameter int ADDR_W = 3,
   parameter int DATA_W = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk_s,
   input  logic              sel_n_s,
   input  logic              sdi_s,
   output logic [ADDR_W-1:0] rd_addr,
   input  logic [DATA_W-1:0] rd_data,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data,
   output logic              sdo,
   output logic              sdo_oe,
   output logic              sel_act
);
   localparam int HDR        = 1 + ADDR_W;
   localparam int FRAME_BITS = HDR + DATA_W;
   localparam int SH_W       = FRAME_BITS - 1;
   localparam int CNT_W      = $clog2(FRAME_BITS + 1);

   logic              sclk_d;
   logic              rise, fall;
   logic [CNT_W-1:0]  cnt;
   logic [SH_W-1:0]   in_sh;
   logic [DATA_W-1:0] out_sh;
   logic              is_rd;

   assign sel_act = ~sel_n_s;
   assign rise    = sel_act &  sclk_s & ~sclk_d;
   assign fall    = sel_act & ~sclk_s &  sclk_d;
   assign rd_addr = in_sh[ADDR_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sclk_d <= 1'b0;
      else        sclk_d <= sclk_s;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= '0;
         in_sh   <= '0;
         out_sh  <= '0;
         is_rd   <= 1'b0;
         wr_en   <= 1'b0;
         wr_addr <= '0;
         wr_data <= '0;
         sdo     <= 1'b0;
         sdo_oe  <= 1'b0;
      end else begin
         wr_en <= 1'b0;
         if (!sel_act) begin
            cnt    <= '0;
            is_rd  <= 1'b0;
            sdo    <= 1'b0;
            sdo_oe <= 1'b0;
         end else begin
            if (rise && cnt < CNT_W'(FRAME_BITS)) begin
               in_sh <= {in_sh[SH_W-2:0], sdi_s};
               cnt   <= cnt + 1'b1;
               if (cnt == CNT_W'(ADDR_W))
                  is_rd <= in_sh[ADDR_W-1];
               if (cnt == CNT_W'(FRAME_BITS-1) && !in_sh[SH_W-1]) begin
                  wr_en   <= 1'b1;
                  wr_addr <= in_sh[SH_W-2 -: ADDR_W];
                  wr_data <= {in_sh[DATA_W-2:0], sdi_s};
               end
            end
            if (fall && is_rd && cnt >= CNT_W'(HDR) && cnt < CNT_W'(FRAME_BITS)) begin
               sdo_oe <= 1'b1;
               if (cnt == CNT_W'(HDR)) begin
                  sdo    <= rd_data[DATA_W-1];
                  out_sh <= {rd_data[DATA_W-2:0], 1'b0};
               end else begin
                  sdo    <= out_sh[DATA_W-1];
                  out_sh <= {out_sh[DATA_W-2:0], 1'b0};
               end
            end
         end
      end
   end
endmodule

// File: rtl/scp_regfile.sv
module scp_regfile #(
   parameter int ADDR_W = 3,
   parameter int DATA_W = 9
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         wr_en,
   input  logic [ADDR_W-1:0]            wr_addr,
   input  logic [DATA_W-1:0]            wr_data,
   input  logic [ADDR_W-1:0]            rd_addr,
   output logic [DATA_W-1:0]            rd_data,
   output logic [2**ADDR_W-1:0][DATA_W-1:0] regs_q
);
   localparam int NREG = 2**ADDR_W;

   for (genvar i = 0; i < NREG; i++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            regs_q[i] <= scp_pkg::reset_val(i);
         else if (wr_en && wr_addr == ADDR_W'(i))
            regs_q[i] <= wr_data & scp_pkg::keep_mask(i);
      end
   end

   assign rd_data = regs_q[rd_addr];
endmodule

// File: rtl/serial_cfg_port.sv
module serial_cfg_port #(
   parameter int SYNC_STAGES = 2,
   parameter int ADDR_W      = scp_pkg::REG_ADDR_W,
   parameter int DATA_W      = scp_pkg::REG_W,
   parameter int GAIN_W      = 6
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         sclk_i,
   input  logic                         sel_n_i,
   input  logic                         sdi_i,
   output logic                         sdo_o,
   output logic                         sdo_oe_o,
   output logic                         range_hi_o,
   output logic                         int_ref_o,
   output logic                         three_ch_o,
   output logic                         cds_o,
   output logic                         clamp_hi_o,
   output logic                         pwrdn_o,
   output logic                         single_byte_o,
   output logic                         order_rgb_o,
   output logic [2:0]                   ch_en_o,
   output logic [2:0][GAIN_W-1:0]       gain_o,
   output logic [2:0][DATA_W-1:0]       ofs_o
);
   import scp_pkg::*;

   localparam int NREG = 2**ADDR_W;

   if (DATA_W != REG_W) begin : g_bad_data_w
      $error("register map is defined for 9-bit registers");
   end
   if (ADDR_W != REG_ADDR_W) begin : g_bad_addr_w
      $error("register map is defined for eight registers");
   end
   if (GAIN_W > DATA_W - 3) begin : g_bad_gain_w
      $error("gain field too wide");
   end

   logic                         sclk_s, sel_n_s, sdi_s;
   logic                         sel_act;
   logic                         wr_en;
   logic [ADDR_W-1:0]            wr_addr, rd_addr;
   logic [DATA_W-1:0]            wr_data, rd_data;
   logic [NREG-1:0][DATA_W-1:0]  regs_q;
   logic [DATA_W-1:0]            cfg_q, mux_q;

   scp_sync #(.STAGES(SYNC_STAGES), .W(3), .RST_VAL(3'b100)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({sel_n_i, sdi_i, sclk_i}),
      .q     ({sel_n_s, sdi_s, sclk_s})
   );

   scp_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frame (
      .clk     (clk),
      .rst_n   (rst_n),
      .sclk_s  (sclk_s),
      .sel_n_s (sel_n_s),
      .sdi_s   (sdi_s),
      .rd_addr (rd_addr),
      .rd_data (rd_data),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .sdo     (sdo_o),
      .sdo_oe  (sdo_oe_o),
      .sel_act (sel_act)
   );

   scp_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rd_addr (rd_addr),
      .rd_data (rd_data),
      .regs_q  (regs_q)
   );

   assign cfg_q         = regs_q[ADDR_CFG];
   assign mux_q         = regs_q[ADDR_MUX];
   assign range_hi_o    = cfg_q[CFG_RANGE];
   assign int_ref_o     = cfg_q[CFG_REF];
   assign three_ch_o    = cfg_q[CFG_3CH];
   assign cds_o         = cfg_q[CFG_CDS];
   assign clamp_hi_o    = cfg_q[CFG_CLAMP];
   assign pwrdn_o       = cfg_q[CFG_PWRDN];
   assign single_byte_o = cfg_q[CFG_1BYTE];
   assign order_rgb_o   = mux_q[MUX_ORDER];
   assign ch_en_o       = mux_q[MUX_EN_LO +: 3];

   logic [NUM_CH-1:0][DATA_W-GAIN_W-1:0] gain_hi_unused;
   logic                                 bits_unused;
   assign bits_unused = ^{cfg_q[8], cfg_q[1], mux_q[8], mux_q[3:0], gain_hi_unused};

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic [DATA_W-1:0] g_r, o_r, mag;
      assign g_r               = regs_q[ADDR_GAIN_R + c];
      assign o_r               = regs_q[ADDR_OFS_R + c];
      assign gain_o[c]         = g_r[GAIN_W-1:0];
      assign gain_hi_unused[c] = g_r[DATA_W-1:GAIN_W];
      assign mag               = {1'b0, o_r[DATA_W-2:0]};
      assign ofs_o[c]          = o_r[DATA_W-1] ? (~mag + 1'b1) : mag;
   end
endmodule

// File: rtl/scp_chk.sv
module scp_chk #(
   parameter int ADDR_W = 3,
   parameter int DATA_W = 9
) (
   input logic                             clk,
   input logic                             rst_n,
   input logic                             sel_act,
   input logic                             wr_en,
   input logic                             sdo_oe,
   input logic [2**ADDR_W-1:0][DATA_W-1:0] regs
);
   // R12: drive released after the select line goes idle
   a_r12_oe_released: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_act |=> !sdo_oe);

   // R3: drive only starts inside an active frame
   a_r3_oe_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sdo_oe) |-> $past(sel_act));

   // R2: a frame commits at most one write pulse
   a_r2_single_commit: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> !wr_en);

   // R10: registers move only on a committed write
   a_r10_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(regs));

   for (genvar i = 0; i < 2**ADDR_W; i++) begin : g_rsv
      // R5: cleared positions stay zero
      a_r5_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
         (regs[i] & ~scp_pkg::keep_mask(i)) == '0);
   end
endmodule

bind serial_cfg_port scp_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .sel_act (sel_act),
   .wr_en   (wr_en),
   .sdo_oe  (sdo_oe_o),
   .regs    (regs_q)
);

// File: tb/tb_serial_cfg_port.sv
module tb_serial_cfg_port;
   localparam int HALF = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sclk = 1'b0, sel_n = 1'b1, sdi = 1'b0;
   logic sdo, sdo_oe;
   logic range_hi, int_ref, three_ch, cds, clamp_hi, pwrdn, single_byte, order_rgb;
   logic [2:0] ch_en;
   logic [2:0][5:0] gain;
   logic [2:0][8:0] ofs;

   int n_chk = 0, n_fail = 0;
   bit finished = 1'b0;

   typedef struct { logic [8:0] val; string tag; } exp_t;
   exp_t exp_q[$];
   logic [8:0] rd_word;
   event rd_done;

   always #2.5 clk = ~clk;

   serial_cfg_port dut (
      .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sel_n_i(sel_n), .sdi_i(sdi),
      .sdo_o(sdo), .sdo_oe_o(sdo_oe), .range_hi_o(range_hi), .int_ref_o(int_ref),
      .three_ch_o(three_ch), .cds_o(cds), .clamp_hi_o(clamp_hi), .pwrdn_o(pwrdn),
      .single_byte_o(single_byte), .order_rgb_o(order_rgb), .ch_en_o(ch_en),
      .gain_o(gain), .ofs_o(ofs)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   // drives nbits of a frame; returns read bits and whether drive was seen
   task automatic frame(input logic rw, input logic [2:0] a, input logic [8:0] d,
                        input int nbits, output logic [8:0] rdv, output logic oe_seen);
      logic [12:0] bits;
      bits = {rw, a, d};
      rdv = '0;
      oe_seen = 1'b0;
      sel_n = 1'b0;
      repeat (4) @(negedge clk);
      for (int i = 0; i < nbits; i++) begin
         sdi = bits[12-i];
         repeat (HALF) @(negedge clk);
         if (i >= 4) rdv = {rdv[7:0], sdo};
         oe_seen = oe_seen | sdo_oe;
         sclk = 1'b1;
         repeat (HALF) @(negedge clk);
         sclk = 1'b0;
      end
      repeat (HALF) @(negedge clk);
      sel_n = 1'b1;
      repeat (6) @(negedge clk);
   endtask

   task automatic wr(input logic [2:0] a, input logic [8:0] d);
      logic [8:0] r; logic oe;
      frame(1'b0, a, d, 13, r, oe);
      chk("R12 no drive in write frame", int'(oe), 0);
   endtask

   task automatic rd(input logic [2:0] a, input logic [8:0] exp, input string tag);
      logic [8:0] r; logic oe;
      exp_t it;
      it.val = exp; it.tag = tag;
      exp_q.push_back(it);
      frame(1'b1, a, 9'h0, 13, r, oe);
      chk("R3 drive during read", int'(oe), 1);
      chk("R12 released after frame", int'(sdo_oe), 0);
      rd_word = r;
      -> rd_done;
   endtask

   // scoreboard monitor
   initial begin
      forever begin
         @(rd_done);
         if (exp_q.size() == 0) chk("scoreboard underflow", 1, 0);
         else begin
            exp_t it;
            it = exp_q.pop_front();
            chk(it.tag, int'(rd_word), int'(it.val));
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      chk("watchdog expired", 1, 0);
      summary();
   end

   initial begin
      logic [8:0] r; logic oe;
      repeat (10) @(negedge clk);
      rst_n = 1'b1;
      repeat (10) @(negedge clk);

      // R4 reset state at the ports
      chk("R4 mode flags", int'({range_hi, int_ref, three_ch, cds, clamp_hi, pwrdn, single_byte}), 7'b1111100);
      chk("R4 order/enables", int'({order_rgb, ch_en}), 4'b1100);
      chk("R4 gains", int'(gain), 0);
      chk("R4 offsets", int'(ofs), 0);
      chk("R4 output enable", int'(sdo_oe), 0);
      rd(3'd0, 9'h0F8, "R4 reg0 reset");
      rd(3'd1, 9'h0C0, "R4 reg1 reset");
      rd(3'd7, 9'h000, "R4 reg7 reset");

      // R1, R8 gains
      wr(3'd2, 9'h02A);
      wr(3'd3, 9'h03F);
      wr(3'd4, 9'h020);
      chk("R8 red gain", int'(gain[0]), 42);
      chk("R8 green gain", int'(gain[1]), 63);
      chk("R1 msb-first blue gain", int'(gain[2]), 32);
      rd(3'd2, 9'h02A, "R2 red gain readback");
      rd(3'd2, 9'h02A, "R3 read leaves register");

      // R5 reserved bits
      wr(3'd3, 9'h1FF);
      rd(3'd3, 9'h03F, "R5 gain mask");
      wr(3'd0, 9'h1FF);
      rd(3'd0, 9'h0FD, "R5 mode mask");
      wr(3'd1, 9'h1FF);
      rd(3'd1, 9'h0F0, "R5 mux mask");

      // R6 mode decode
      wr(3'd0, 9'h005);
      chk("R6 decode 0x005", int'({range_hi, int_ref, three_ch, cds, clamp_hi, pwrdn, single_byte}), 7'b0000011);
      wr(3'd0, 9'h0A8);
      chk("R6 decode 0x0A8", int'({range_hi, int_ref, three_ch, cds, clamp_hi, pwrdn, single_byte}), 7'b1010100);

      // R7 mux decode
      wr(3'd1, 9'h030);
      chk("R7 order", int'(order_rgb), 0);
      chk("R7 enables", int'(ch_en), 3'b011);

      // R9 offsets
      wr(3'd5, 9'h1FF);
      wr(3'd6, 9'h001);
      wr(3'd7, 9'h100);
      chk("R9 red -255", int'($signed(ofs[0])), -255);
      chk("R9 green +1", int'($signed(ofs[1])), 1);
      chk("R9 blue neg zero", int'($signed(ofs[2])), 0);
      rd(3'd5, 9'h1FF, "R9 red offset readback");
      rd(3'd6, 9'h001, "R1 address separation");

      // R10 short frames
      frame(1'b0, 3'd2, 9'h011, 6, r, oe);
      frame(1'b0, 3'd2, 9'h011, 12, r, oe);
      chk("R10 gain unchanged", int'(gain[0]), 42);
      rd(3'd2, 9'h02A, "R10 short frame discarded");

      // R11 power-down keeps state, accepts writes
      wr(3'd0, 9'h004);
      chk("R11 power-down set", int'(pwrdn), 1);
      chk("R11 offsets kept", int'($signed(ofs[0])), -255);
      wr(3'd4, 9'h015);
      rd(3'd4, 9'h015, "R11 write while powered down");
      rd(3'd2, 9'h02A, "R11 red gain kept");

      repeat (20) @(negedge clk);
      chk("scoreboard drained", exp_q.size(), 0);
      summary();
   end
endmodule